// File: doc/BRIEF.md
# Full-Duplex Serial Transceiver with Two-Entry Receive Queue

This block is an asynchronous serial transceiver for a register-mapped peripheral slot. A programmable divider makes a 16x oversampling tick. The transmitter and the receiver run on that tick at the same time and do not depend on each other. Software or a DMA engine loads one byte into a single transmit holding register. The block moves that byte into its shifter and sends it as a frame: one start bit, 7 or 8 data bits least significant bit first, an optional odd or even parity bit, then one or two stop bits.

Received frames go into a two-entry queue. The queue raises separate events when it has stored a byte and when it has become completely full. A third frame that arrives while both entries are occupied is dropped, and an overrun is recorded. Seven sticky event flags are cleared by writing one to them. An interrupt line combines the flags that are enabled. Two gated DMA strobes follow byte arrival and transmit-holding-register release. Each serial pin has its own polarity inversion control.

Top module: `sio_uart`

## Requirements
- R1: Each bit period is 16*(cfg_div+1) clock cycles. With cfg_div=3, a frame of byte 0x00 with 8 data bits and no parity keeps tx_pin low for 576 cycles, give or take the tick phase.
- R2: The line idles high. A transmitted frame is one low start bit, then 8 data bits (cfg_len8=1) or 7 data bits (cfg_len8=0) least significant bit first, then the parity bit if enabled, then one (cfg_stop2=0) or two (cfg_stop2=1) high stop bits. A received 7-bit character appears on rd_data with bit 7 cleared.
- R3: Parity is enabled by cfg_par_en. cfg_par_odd=0 selects even parity and cfg_par_odd=1 selects odd parity, counted over the data bits plus the parity bit. A received parity mismatch sets flag bit 4, and the byte is still stored.
- R4: The receiver accepts a start bit only if the line is still low half a bit period after the falling edge. A shorter low pulse stores nothing, and rx_busy returns to 0.
- R5: Received bytes leave in arrival order. rx_level counts 0 to 2, and rd_en removes the head byte shown on rd_data. Flag bit 0 is set on every stored byte, and flag bit 1 is set when rx_level reaches 2.
- R6: A frame that completes while rx_level is 2 is discarded. The two buffered bytes are kept, and flag bit 6 (overrun) is set.
- R7: A stop bit sampled low sets flag bit 5 (framing error).
- R8: The transmit holding register holds one byte, and tx_full shows when it is occupied. A write while tx_full=1 is ignored. Flag bit 2 is set when the held byte moves into the shifter.
- R9: Flag bit 3 (end of transmission) is set when the last stop bit completes while the holding register is empty.
- R10: Writing 1 to a bit of irq_clr clears that flag unless the flag's event occurs in the same cycle. irq is high when any flag is set whose irq_en bit is also set.
- R11: dma_rx_req pulses once for each stored byte when dma_rx_en=1. dma_tx_req pulses once for each release of the holding register when dma_tx_en=1.
- R12: cfg_inv_tx inverts tx_pin, and cfg_inv_rx inverts rx_pin before the receiver sees it. With both inversions set, the idle tx_pin is low.
- R13: soft_rst returns both state machines, the receive queue, the holding register and all flags to their reset state.
- R14: tx_busy is 1 from the moment a frame starts until its last stop bit ends. rx_busy is 1 while the receiver is inside a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous return of all engines, buffers and flags to idle |
| cfg_div | input | 8 | Baud divider reload value; tick period is cfg_div+1 cycles |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | 1 = two stop bits on transmit |
| cfg_inv_tx | input | 1 | Invert the serial output |
| cfg_inv_rx | input | 1 | Invert the serial input |
| wr_en | input | 1 | Write wr_data into the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit holding register occupied |
| rd_en | input | 1 | Remove the head byte of the receive queue |
| rd_data | output | 8 | Head byte of the receive queue |
| rx_level | output | 2 | Number of bytes in the receive queue |
| tx_busy | output | 1 | Transmitter inside a frame |
| rx_busy | output | 1 | Receiver inside a frame |
| irq_en | input | 7 | Per-flag interrupt enables |
| irq_clr | input | 7 | Write-one-to-clear strobes for the flags |
| irq_flags | output | 7 | Sticky flags: 0 byte stored, 1 queue full, 2 holding released, 3 transmit end, 4 parity, 5 framing, 6 overrun |
| irq | output | 1 | Any enabled flag set |
| dma_rx_en | input | 1 | Enable receive DMA strobe |
| dma_tx_en | input | 1 | Enable transmit DMA strobe |
| dma_rx_req | output | 1 | One-cycle receive DMA request |
| dma_tx_req | output | 1 | One-cycle transmit DMA request |
| rx_pin | input | 1 | Serial input |
| tx_pin | output | 1 | Serial output |

## Verification
The bench sends a third frame into a full queue. A design that overwrote an entry or advanced a pointer would return the wrong bytes or the wrong order. It writes into an occupied holding register, where a design that accepted the write would send a corrupted second frame. It drives low glitches shorter than half a bit, which a receiver without the midpoint check would turn into a phantom byte. It also sweeps 7-bit, two-stop, odd and even frames at several divider values, so that a miscounted bit index, a parity of the wrong sense or a stop counted once would show up as a frame mismatch or a wrong flag.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int FLAG_W = 7;
  localparam int FL_RX1 = 0;
  localparam int FL_RX2 = 1;
  localparam int FL_TXE = 2;
  localparam int FL_END = 3;
  localparam int FL_PAR = 4;
  localparam int FL_FRM = 5;
  localparam int FL_OVR = 6;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } frame_st_t;
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             srst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (srst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= div;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end

  // R1: the down-counter never exceeds the programmed reload
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (srst)
    (tick && $stable(div)) |-> (cnt <= div));
endmodule

// File: rtl/sio_tx.sv
module sio_tx import sio_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              tick,
  input  logic              len8,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop2,
  input  logic              load_vld,
  input  logic [DATA_W-1:0] load_data,
  output logic              load_ack,
  output logic              line,
  output logic              busy,
  output logic              done
);
  localparam int TW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W);

  frame_st_t         state;
  logic [TW-1:0]     tcnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] sh;
  logic              pbit;
  logic              sbit;
  logic [DATA_W-1:0] lmask;
  logic              bit_end;
  logic [BW-1:0]     last_idx;

  assign load_ack = (state == ST_IDLE) && load_vld;
  assign busy     = (state != ST_IDLE);
  assign lmask    = len8 ? load_data : {1'b0, load_data[DATA_W-2:0]};
  assign bit_end  = tick && (tcnt == TW'(OVS-1));
  assign last_idx = len8 ? BW'(DATA_W-1) : BW'(DATA_W-2);

  always_ff @(posedge clk) begin
    if (srst) begin
      state <= ST_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
      sbit  <= 1'b0;
      line  <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) tcnt <= bit_end ? '0 : tcnt + 1'b1;
      case (state)
        ST_IDLE: begin
          line <= 1'b1;
          if (load_vld) begin
            sh    <= load_data;
            pbit  <= (^lmask) ^ par_odd;
            tcnt  <= '0;
            line  <= 1'b0;
            state <= ST_START;
          end
        end
        ST_START: if (bit_end) begin
          line  <= sh[0];
          bidx  <= '0;
          state <= ST_DATA;
        end
        ST_DATA: if (bit_end) begin
          if (bidx == last_idx) begin
            sbit <= 1'b0;
            if (par_en) begin
              line  <= pbit;
              state <= ST_PAR;
            end else begin
              line  <= 1'b1;
              state <= ST_STOP;
            end
          end else begin
            bidx <= bidx + 1'b1;
            sh   <= sh >> 1;
            line <= sh[1];
          end
        end
        ST_PAR: if (bit_end) begin
          line  <= 1'b1;
          state <= ST_STOP;
        end
        ST_STOP: if (bit_end) begin
          if (stop2 && !sbit) begin
            sbit <= 1'b1;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: start bit is driven low, stop bits are driven high
  p_start_low_r2: assert property (@(posedge clk) disable iff (srst)
    (state == ST_START) |-> !line);
  p_stop_high_r2: assert property (@(posedge clk) disable iff (srst)
    (state == ST_STOP) |-> line);
  // R14: completion pulse only as the transmitter goes idle
  p_done_idle_r14: assert property (@(posedge clk) disable iff (srst)
    done |-> (state == ST_IDLE));
endmodule

// File: rtl/sio_rx.sv
module sio_rx import sio_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              tick,
  input  logic              rxd,
  input  logic              len8,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr,
  output logic              busy
);
  localparam int TW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W);

  frame_st_t         state;
  logic [TW-1:0]     tcnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] sh;
  logic              pbit;
  logic [DATA_W-1:0] dfull;
  logic              bit_end;
  logic              mid_end;
  logic [BW-1:0]     last_idx;

  assign busy     = (state != ST_IDLE);
  assign dfull    = len8 ? sh : {1'b0, sh[DATA_W-1:1]};
  assign bit_end  = tick && (tcnt == TW'(OVS-1));
  assign mid_end  = tick && (tcnt == TW'(OVS/2-1));
  assign last_idx = len8 ? BW'(DATA_W-1) : BW'(DATA_W-2);

  always_ff @(posedge clk) begin
    if (srst) begin
      state <= ST_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
      done  <= 1'b0;
      data  <= '0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (!rxd) begin
          tcnt  <= '0;
          state <= ST_START;
        end
        ST_START: if (mid_end) begin
          tcnt <= '0;
          bidx <= '0;
          state <= rxd ? ST_IDLE : ST_DATA;
        end else if (tick) begin
          tcnt <= tcnt + 1'b1;
        end
        ST_DATA: if (bit_end) begin
          tcnt <= '0;
          sh   <= {rxd, sh[DATA_W-1:1]};
          if (bidx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
          else                  bidx  <= bidx + 1'b1;
        end else if (tick) begin
          tcnt <= tcnt + 1'b1;
        end
        ST_PAR: if (bit_end) begin
          tcnt  <= '0;
          pbit  <= rxd;
          state <= ST_STOP;
        end else if (tick) begin
          tcnt <= tcnt + 1'b1;
        end
        ST_STOP: if (bit_end) begin
          tcnt  <= '0;
          data  <= dfull;
          perr  <= par_en && (pbit != ((^dfull) ^ par_odd));
          ferr  <= !rxd;
          done  <= 1'b1;
          state <= ST_IDLE;
        end else if (tick) begin
          tcnt <= tcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: a start bit high at its midpoint aborts back to idle
  p_false_start_r4: assert property (@(posedge clk) disable iff (srst)
    (state == ST_START && mid_end && rxd) |=> (state == ST_IDLE));
  // R7: a frame result is only produced as the receiver leaves the stop bit
  p_done_idle_r7: assert property (@(posedge clk) disable iff (srst)
    done |-> (state == ST_IDLE && $past(state) == ST_STOP));
endmodule

// File: rtl/sio_rxbuf.sv
module sio_rxbuf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [LVL_W-1:0]  level,
  output logic              acc,
  output logic              pop_ok,
  output logic              drop
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok = pop && (level != '0);
  assign acc    = push && ((level != LVL_W'(DEPTH)) || pop_ok);
  assign drop   = push && !acc;
  assign head   = mem[rptr];

  always_ff @(posedge clk) begin
    if (acc) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (acc)    wptr <= nxt(wptr);
      if (pop_ok) rptr <= nxt(rptr);
      case ({acc, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R6: occupancy never passes the depth; a dropped frame leaves it full
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (srst)
    level <= LVL_W'(DEPTH));
  p_drop_keeps_r6: assert property (@(posedge clk) disable iff (srst)
    drop |=> (level == LVL_W'(DEPTH)));
endmodule

// File: rtl/sio_uart.sv
module sio_uart import sio_pkg::*; #(
  parameter int DIV_W    = 8,
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int RX_DEPTH = 2,
  parameter int SYNC_N   = 2,
  localparam int LVL_W   = $clog2(RX_DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_len8,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              cfg_inv_tx,
  input  logic              cfg_inv_rx,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  rx_level,
  output logic              tx_busy,
  output logic              rx_busy,
  input  logic [FLAG_W-1:0] irq_en,
  input  logic [FLAG_W-1:0] irq_clr,
  output logic [FLAG_W-1:0] irq_flags,
  output logic              irq,
  input  logic              dma_rx_en,
  input  logic              dma_tx_en,
  output logic              dma_rx_req,
  output logic              dma_tx_req,
  input  logic              rx_pin,
  output logic              tx_pin
);
  logic              srst;
  logic              tick;
  logic [SYNC_N-1:0] sy;
  logic              rxd;
  logic [DATA_W-1:0] tx_hold;
  logic              ld_ack, tx_line, tx_done;
  logic              rx_done, rx_perr, rx_ferr;
  logic [DATA_W-1:0] rx_data;
  logic              rx_acc, rx_pop_ok, rx_drop;
  logic [FLAG_W-1:0] set_v;

  assign srst = rst | soft_rst;

  always_ff @(posedge clk) begin
    if (srst) sy <= '1;
    else      sy <= {sy[SYNC_N-2:0], rx_pin};
  end
  assign rxd    = sy[SYNC_N-1] ^ cfg_inv_rx;
  assign tx_pin = tx_line ^ cfg_inv_tx;

  sio_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .srst(srst), .div(cfg_div), .tick(tick));

  sio_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .srst(srst), .tick(tick), .len8(cfg_len8), .par_en(cfg_par_en),
    .par_odd(cfg_par_odd), .stop2(cfg_stop2), .load_vld(tx_full),
    .load_data(tx_hold), .load_ack(ld_ack), .line(tx_line), .busy(tx_busy),
    .done(tx_done));

  sio_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .srst(srst), .tick(tick), .rxd(rxd), .len8(cfg_len8),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .done(rx_done), .data(rx_data),
    .perr(rx_perr), .ferr(rx_ferr), .busy(rx_busy));

  sio_rxbuf #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_rxbuf (
    .clk(clk), .srst(srst), .push(rx_done), .push_data(rx_data), .pop(rd_en),
    .head(rd_data), .level(rx_level), .acc(rx_acc), .pop_ok(rx_pop_ok),
    .drop(rx_drop));

  // transmit holding register
  always_ff @(posedge clk) begin
    if (srst) begin
      tx_full <= 1'b0;
      tx_hold <= '0;
    end else if (ld_ack) begin
      tx_full <= 1'b0;
    end else if (wr_en && !tx_full) begin
      tx_full <= 1'b1;
      tx_hold <= wr_data;
    end
  end

  always_comb begin
    set_v         = '0;
    set_v[FL_RX1] = rx_acc;
    set_v[FL_RX2] = rx_acc && !rx_pop_ok && (rx_level == LVL_W'(RX_DEPTH-1));
    set_v[FL_TXE] = ld_ack;
    set_v[FL_END] = tx_done && !tx_full;
    set_v[FL_PAR] = rx_done && rx_perr;
    set_v[FL_FRM] = rx_done && rx_ferr;
    set_v[FL_OVR] = rx_drop;
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      irq_flags  <= '0;
      irq        <= 1'b0;
      dma_rx_req <= 1'b0;
      dma_tx_req <= 1'b0;
    end else begin
      irq_flags  <= (irq_flags & ~irq_clr) | set_v;
      irq        <= |(irq_flags & irq_en);
      dma_rx_req <= dma_rx_en && set_v[FL_RX1];
      dma_tx_req <= dma_tx_en && set_v[FL_TXE];
    end
  end

  // R8: the transmitter only takes a byte from an occupied holding register
  p_ack_full_r8: assert property (@(posedge clk) disable iff (srst)
    ld_ack |-> tx_full);
  // R10: write-one clears a flag when no new event arrives
  p_w1c_r10: assert property (@(posedge clk) disable iff (srst)
    (irq_clr[FL_OVR] && !rx_drop) |=> !irq_flags[FL_OVR]);
  // R11: DMA strobes only when their enable was set
  p_dma_rx_gate_r11: assert property (@(posedge clk) disable iff (srst)
    dma_rx_req |-> $past(dma_rx_en));
  p_dma_tx_gate_r11: assert property (@(posedge clk) disable iff (srst)
    dma_tx_req |-> $past(dma_tx_en));
endmodule

// File: tb/sio_uart_tb.sv
module sio_uart_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       soft_rst = 1'b0;
  logic [7:0] cfg_div = '0;
  logic       cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic       cfg_inv_tx = 1'b0, cfg_inv_rx = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_full;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] rx_level;
  logic       tx_busy, rx_busy;
  logic [6:0] irq_en = '0, irq_clr = '0, irq_flags;
  logic       irq;
  logic       dma_rx_en = 1'b0, dma_tx_en = 1'b0, dma_rx_req, dma_tx_req;
  logic       loop = 1'b1, drv = 1'b1;
  logic       rx_pin, tx_pin;
  int         n_chk = 0, n_bad = 0, n_drx = 0, n_dtx = 0;

  assign rx_pin = loop ? tx_pin : drv;

  always #4 clk = ~clk;

  sio_uart u_dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_div(cfg_div),
    .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cfg_inv_tx(cfg_inv_tx), .cfg_inv_rx(cfg_inv_rx),
    .wr_en(wr_en), .wr_data(wr_data), .tx_full(tx_full), .rd_en(rd_en),
    .rd_data(rd_data), .rx_level(rx_level), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq_flags(irq_flags), .irq(irq),
    .dma_rx_en(dma_rx_en), .dma_tx_en(dma_tx_en), .dma_rx_req(dma_rx_req),
    .dma_tx_req(dma_tx_req), .rx_pin(rx_pin), .tx_pin(tx_pin));

  always @(negedge clk) begin
    if (dma_rx_req) n_drx++;
    if (dma_tx_req) n_dtx++;
  end

  // {len8, par_en, par_odd, stop2, div[3:0], data[7:0]}
  localparam logic [15:0] VEC [8] = '{
    16'h80A5, 16'hC03C, 16'hF07E, 16'h0055,
    16'h5181, 16'h602A, 16'hE2FF, 16'hD000};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic clr_all();
    @(negedge clk); irq_clr = 7'h7F;
    @(negedge clk); irq_clr = 7'h00;
  endtask

  task automatic wait_fall();
    for (int i = 0; i < 4000 && tx_pin !== 1'b0; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && tx_busy !== 1'b0; i++) @(negedge clk);
  endtask

  // bench-side serial source, 16 cycles per bit (cfg_div = 0)
  task automatic send(input logic [7:0] d, input bit badpar, input bit badstop);
    int nb;
    logic [7:0] m;
    nb = cfg_len8 ? 8 : 7;
    m  = cfg_len8 ? d : {1'b0, d[6:0]};
    drv = 1'b0; tick_n(16);
    for (int i = 0; i < nb; i++) begin drv = d[i]; tick_n(16); end
    if (cfg_par_en) begin drv = (^m) ^ cfg_par_odd ^ badpar; tick_n(16); end
    drv = !badstop; tick_n(16);
    drv = 1'b1; tick_n(24);
  endtask

  // capture one 8N1 frame from tx_pin at div 0
  task automatic grab(output logic [7:0] d);
    wait_fall();
    tick_n(8);
    for (int i = 0; i < 8; i++) begin tick_n(16); d[i] = tx_pin; end
    tick_n(16);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all-requirements act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] g;
    int cyc;
    tick_n(4);
    rst = 1'b0;
    tick_n(4);
    // reset state
    chk(tx_pin === 1'b1, "R2 idle high after reset", tx_pin, 1);
    chk(rx_level === 2'd0 && tx_full === 1'b0, "R5 empty after reset", rx_level, 0);
    chk(irq_flags === 7'h00 && irq === 1'b0, "R10 flags clear after reset", irq_flags, 0);
    chk(tx_busy === 1'b0 && rx_busy === 1'b0, "R14 not busy after reset", tx_busy, 0);

    // vector table walked in loopback
    for (int v = 0; v < 8; v++) begin
      logic [15:0] e;
      logic [7:0]  m;
      int bitc, nb, bad;
      e = VEC[v];
      cfg_len8 = e[15]; cfg_par_en = e[14]; cfg_par_odd = e[13]; cfg_stop2 = e[12];
      cfg_div = {4'h0, e[11:8]};
      tick_n(40);
      clr_all();
      put(e[7:0]);
      bitc = 16 * (e[11:8] + 1);
      nb = e[15] ? 8 : 7;
      m = e[15] ? e[7:0] : {1'b0, e[6:0]};
      bad = 0;
      wait_fall();
      tick_n(bitc / 2);
      if (tx_pin !== 1'b0) bad++;
      for (int i = 0; i < nb; i++) begin tick_n(bitc); if (tx_pin !== m[i]) bad++; end
      if (e[14]) begin tick_n(bitc); if (tx_pin !== ((^m) ^ e[13])) bad++; end
      for (int s = 0; s < (e[12] ? 2 : 1); s++) begin tick_n(bitc); if (tx_pin !== 1'b1) bad++; end
      chk(bad == 0, "R2 R3 R1 transmitted frame bits", bad, 0);
      wait_idle();
      tick_n(4);
      chk(rx_level === 2'd1 && rd_data === m, "R2 R5 looped-back byte", rd_data, m);
      chk(irq_flags === 7'h0D, "R9 R8 flags after single frame", irq_flags, 7'h0D);
      pop();
    end

    // directed: receive queue, flags, DMA
    cfg_div = 0; cfg_len8 = 1; cfg_par_en = 0; cfg_par_odd = 0; cfg_stop2 = 0;
    loop = 1'b0; drv = 1'b1;
    tick_n(40);
    clr_all();
    irq_en = 7'b0000010; dma_rx_en = 1'b1; n_drx = 0;
    send(8'h11, 0, 0);
    chk(rx_level === 2'd1 && irq_flags === 7'h01, "R5 one byte stored flag", irq_flags, 7'h01);
    chk(irq === 1'b0, "R10 irq masked while only bit0 set", irq, 0);
    send(8'h22, 0, 0);
    chk(rx_level === 2'd2 && irq_flags === 7'h03, "R5 two bytes full flag", irq_flags, 7'h03);
    chk(irq === 1'b1, "R10 irq from enabled flag", irq, 1);
    chk(n_drx == 2, "R11 rx DMA pulses", n_drx, 2);
    send(8'h33, 0, 0);
    chk(rx_level === 2'd2 && irq_flags[6] === 1'b1, "R6 overrun flagged", irq_flags, 7'h43);
    chk(n_drx == 2, "R11 no DMA for dropped byte", n_drx, 2);
    chk(rd_data === 8'h11, "R5 R6 head is oldest byte", rd_data, 8'h11);
    pop();
    chk(rd_data === 8'h22, "R5 R6 second byte kept", rd_data, 8'h22);
    pop();
    chk(rx_level === 2'd0, "R5 queue drained", rx_level, 0);
    irq_en = 7'h00; dma_rx_en = 1'b0;
    clr_all();

    // parity and framing errors, selective clear
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send(8'h0F, 1, 0);
    chk(irq_flags[4] === 1'b1 && rd_data === 8'h0F, "R3 parity error flagged byte kept", irq_flags, 7'h11);
    pop();
    cfg_par_en = 1'b0;
    send(8'h5C, 0, 1);
    chk(irq_flags[5] === 1'b1, "R7 framing error flagged", irq_flags, 7'h31);
    pop();
    @(negedge clk); irq_clr = 7'b0100000;
    @(negedge clk); irq_clr = 7'b0000000;
    chk(irq_flags[5] === 1'b0 && irq_flags[4] === 1'b1, "R10 write-one clears only bit5", irq_flags, 7'h11);
    irq_en = 7'b0010000;
    tick_n(3);
    chk(irq === 1'b1, "R10 irq from parity flag", irq, 1);
    irq_en = 7'h00;
    tick_n(3);
    chk(irq === 1'b0, "R10 irq drops when disabled", irq, 0);
    clr_all();

    // short low glitch
    drv = 1'b0; tick_n(5);
    chk(rx_busy === 1'b1, "R14 rx busy on start edge", rx_busy, 1);
    drv = 1'b1; tick_n(40);
    chk(rx_level === 2'd0 && rx_busy === 1'b0, "R4 glitch rejected", rx_level, 0);
    chk(irq_flags === 7'h00, "R4 no flags after glitch", irq_flags, 0);

    // holding register, ignored write, DMA tx, end of transmission
    dma_tx_en = 1'b1; n_dtx = 0;
    put(8'hA1);
    tick_n(2);
    chk(tx_busy === 1'b1 && tx_full === 1'b0, "R14 R8 busy and holding free", tx_full, 0);
    put(8'hB2);
    chk(tx_full === 1'b1, "R8 holding occupied", tx_full, 1);
    put(8'hC3);
    grab(g);
    chk(g === 8'hA1, "R8 first frame", g, 8'hA1);
    grab(g);
    chk(g === 8'hB2, "R8 second frame, ignored write absent", g, 8'hB2);
    wait_idle();
    tick_n(300);
    chk(tx_pin === 1'b1 && tx_busy === 1'b0, "R8 no third frame", tx_busy, 0);
    chk(n_dtx == 2, "R11 tx DMA pulses", n_dtx, 2);
    chk(irq_flags[3] === 1'b1 && irq_flags[2] === 1'b1, "R9 end of transmission", irq_flags, 7'h0C);
    dma_tx_en = 1'b0;
    clr_all();

    // baud period at div 3
    cfg_div = 8'd3;
    tick_n(20);
    put(8'h00);
    wait_fall();
    cyc = 0;
    for (int i = 0; i < 2000 && tx_pin === 1'b0; i++) begin @(negedge clk); cyc++; end
    chk(cyc >= 572 && cyc <= 577, "R1 low time of nine bits", cyc, 576);
    wait_idle();
    cfg_div = 8'd0;
    clr_all();

    // inversion in loopback
    loop = 1'b1; cfg_inv_tx = 1'b1; cfg_inv_rx = 1'b1;
    tick_n(40);
    chk(tx_pin === 1'b0, "R12 inverted idle low", tx_pin, 0);
    put(8'h5A);
    tick_n(250);
    chk(rx_level === 2'd1 && rd_data === 8'h5A, "R12 inverted loopback byte", rd_data, 8'h5A);
    pop();
    cfg_inv_tx = 1'b0; cfg_inv_rx = 1'b0;
    tick_n(40);

    // soft reset
    loop = 1'b0;
    send(8'h77, 0, 0);
    put(8'h99);
    tick_n(30);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    tick_n(2);
    chk(rx_level === 2'd0 && tx_busy === 1'b0 && tx_pin === 1'b1, "R13 engines idle after soft reset", rx_level, 0);
    chk(irq_flags === 7'h00 && tx_full === 1'b0, "R13 flags and holding cleared", irq_flags, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule